// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block produces count-enable strobes for a group of timer channels (two by default) from one common divider. Each channel has a 3-bit select input. The select chooses where that channel's strobe comes from: nothing at all, every system clock, one of four divided taps, or an external edge pulse. The edge pulse is already synchronised and edge-detected outside this block. Each strobe is one system clock wide and is meant to feed the count enable of a timer counter.

The divider is a 10-bit counter that runs freely. It advances on every clock whatever the selects are. As a result, the phase of a divided tap is fixed by the shared counter and not by the moment a channel selects it. A synchronous clear input restarts the counter at zero. Because the counter is shared, a clear requested on behalf of one channel moves the tap phase for every channel.

Top module: `shared_prescaler`

## Requirements
- R1: Select code 0 stops the channel, and its `cnt_en_o` bit stays low.
- R2: Select code 1 drives the channel's `cnt_en_o` bit high on every clock while reset is released.
- R3: The shared divider is a 10-bit counter. It is zero while `rst_n` is low and adds one on every clock otherwise, wrapping from 1023 to 0. The select inputs never affect it.
- R4: Select codes 2, 3, 4 and 5 choose divide ratios 8, 64, 256 and 1024, using the divider's low 3, 6, 8 and 10 bits. The strobe is high for exactly the one clock in which those low bits are all ones, which is the clock just before they roll over to zero.
- R5: When `psc_clr_i` is high at a clock edge, the divider is zero after that edge. A channel on ratio 8 then first strobes in the eighth clock after the clear cycle, and this holds for every channel.
- R6: Select code 6 passes that channel's `ext_fall_i` pulse to its output, and code 7 passes its `ext_rise_i` pulse.
- R7: Each channel decodes its own select, and all channels read their taps from the same divider phase.
- R8: After a channel switches to a divided tap of ratio N, its first strobe appears within N clocks. This is inside the 1 to N+1 window.
- R9: While `rst_n` is low, every `cnt_en_o` bit is low. After release, a ratio-8 channel first strobes in the eighth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psc_clr_i | input | 1 | Synchronous clear of the shared divider |
| sel_i | input | NUM_CH x 3 | Per-channel source select code |
| ext_rise_i | input | NUM_CH | Per-channel rising-edge pulse from external clock logic |
| ext_fall_i | input | NUM_CH | Per-channel falling-edge pulse from external clock logic |
| cnt_en_o | output | NUM_CH | Per-channel one-clock count-enable strobe |

## Verification
The bench builds the block with its defaults: two channels and a 10-bit divider. Two channels are enough to show two different taps, and a clear, acting on one shared phase at the same time. The 10-bit width keeps a full 1024-clock divider wrap short enough to run several times. That makes the slowest tap, its nesting with the faster taps, and the worst-case first-strobe delay for every ratio all reachable in a short directed run.

// File: rtl/prescale_pkg.sv
// Package: shared types and constants for the timer clock prescaler.
// Assumes the select code is 3 bits wide and there are four divided taps.
package prescale_pkg;

    localparam int SEL_W   = 3;
    localparam int TAP_NUM = 4;

    // Source select codes; the numeric values are part of the block's behaviour.
    typedef enum logic [SEL_W-1:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_EXT_FALL = 3'd6,
        SRC_EXT_RISE = 3'd7
    } src_sel_e;

    // Number of low divider bits that set the period of tap i (ratio 2**shift).
    function automatic int tap_shift(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/presc_divider.sv
// Module: presc_divider
// A free-running binary counter shared by every channel. It ignores the
// selects completely. A synchronous reset or a clear forces it to zero.
// Assumes DIV_W covers the widest tap shift.
module presc_divider #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [DIV_W-1:0] cnt_o
);

    // Advance the shared divider, or restart it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R5: a clear leaves the divider at zero.
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    // R3: without a clear the divider moves forward by exactly one.
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_o == DIV_W'($past(cnt_o) + 1'b1)));

endmodule

// File: rtl/presc_tap_decode.sv
// Module: presc_tap_decode
// Turns the shared divider value into one strobe per divided tap. A tap
// is high in the single clock where its low bits are all ones, just
// before they roll over. Assumes DIV_W >= the widest tap shift.
module presc_tap_decode
    import prescale_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   cnt_i,
    output logic [TAP_NUM-1:0] tap_o
);

    for (genvar g = 0; g < TAP_NUM; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        // Detect the last clock of this tap's period.
        assign tap_o[g] = &cnt_i[SH-1:0];

        if (g > 0) begin : g_nest
            // R4: a slower tap fires only when every faster tap also fires.
            p_tap_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tap_o[g] |-> tap_o[g-1]);
        end
    end

    // R4: the fastest tap is one clock wide.
    p_tap_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o[0] |=> !tap_o[0]);

endmodule

// File: rtl/presc_chan_mux.sv
// Module: presc_chan_mux
// For one channel, picks the count-enable source named by its select
// code. The output is forced low while reset is held. Assumes the
// external pulses are already synchronised and one clock wide.
module presc_chan_mux
    import prescale_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [TAP_NUM-1:0] tap_i,
    input  logic               ext_rise_i,
    input  logic               ext_fall_i,
    output logic               en_o
);

    logic pick;

    // Choose the strobe source from the select code.
    always_comb begin
        case (src_sel_e'(sel_i))
            SRC_OFF:      pick = 1'b0;
            SRC_SYS:      pick = 1'b1;
            SRC_DIV8:     pick = tap_i[0];
            SRC_DIV64:    pick = tap_i[1];
            SRC_DIV256:   pick = tap_i[2];
            SRC_DIV1024:  pick = tap_i[3];
            SRC_EXT_FALL: pick = ext_fall_i;
            SRC_EXT_RISE: pick = ext_rise_i;
            default:      pick = 1'b0;
        endcase
    end

    // Hold the output low during reset.
    assign en_o = pick & rst_n;

    // R1: a stopped channel never strobes.
    p_stop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd0) |-> !en_o);

    // R2: direct mode strobes every clock.
    p_direct_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd1) |-> en_o);

    // R6: the external modes follow their edge pulses.
    p_ext_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd7) |-> (en_o == ext_rise_i));
    p_ext_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd6) |-> (en_o == ext_fall_i));

endmodule

// File: rtl/shared_prescaler.sv
// Module: shared_prescaler
// Top of the prescaler. One free-running divider and one tap decoder feed
// NUM_CH independent source multiplexers, one per timer channel.
// Assumes DIV_W is at least 10 so that the ratio-1024 tap exists.
module shared_prescaler
    import prescale_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DIV_W  = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        psc_clr_i,
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel_i,
    input  logic [NUM_CH-1:0]           ext_rise_i,
    input  logic [NUM_CH-1:0]           ext_fall_i,
    output logic [NUM_CH-1:0]           cnt_en_o
);

    logic [DIV_W-1:0]   div_cnt;
    logic [TAP_NUM-1:0] taps;

    presc_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (psc_clr_i),
        .cnt_o (div_cnt)
    );

    presc_tap_decode #(.DIV_W(DIV_W)) u_taps (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_i (div_cnt),
        .tap_o (taps)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        presc_chan_mux u_mux (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (sel_i[c]),
            .tap_i      (taps),
            .ext_rise_i (ext_rise_i[c]),
            .ext_fall_i (ext_fall_i[c]),
            .en_o       (cnt_en_o[c])
        );
    end

    // R9: no channel strobes while reset is held.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (cnt_en_o == '0));

endmodule

// File: tb/shared_prescaler_tb.sv
// Directed bench for shared_prescaler. Expected values come from a bench
// model of the requirements: a divider reference and a select decode.
module shared_prescaler_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int WATCHDOG   = 150000;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     psc_clr_i = 1'b0;
    logic [NCH-1:0][2:0]      sel_i = '0;
    logic [NCH-1:0]           ext_rise_i = '0;
    logic [NCH-1:0]           ext_fall_i = '0;
    logic [NCH-1:0]           cnt_en_o;

    int total = 0;
    int bad   = 0;
    int ref_cnt = 0;
    int cycles  = 0;

    shared_prescaler #(.NUM_CH(NCH), .DIV_W(10)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .psc_clr_i  (psc_clr_i),
        .sel_i      (sel_i),
        .ext_rise_i (ext_rise_i),
        .ext_fall_i (ext_fall_i),
        .cnt_en_o   (cnt_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference divider per R3 and R5.
    always @(posedge clk) begin
        if (!rst_n || psc_clr_i) ref_cnt <= 0;
        else                     ref_cnt <= (ref_cnt + 1) % 1024;
    end

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Expected strobe from the select codes in R1, R2, R4, R6 and R9.
    function automatic logic exp_en(int sel, logic r, logic f, int c, logic rn);
        if (!rn) return 1'b0;
        case (sel)
            0: return 1'b0;
            1: return 1'b1;
            2: return (c % 8) == 7;
            3: return (c % 64) == 63;
            4: return (c % 256) == 255;
            5: return (c % 1024) == 1023;
            6: return f;
            default: return r;
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0b expected=%0b (div=%0d)", req, act, exp, ref_cnt);
        end
    endtask

    // Check all channels 1 time unit after the inputs change, then move to the next negedge.
    task automatic cyc(string req);
        #1;
        for (int c = 0; c < NCH; c++)
            check(req, cnt_en_o[c], exp_en(int'(sel_i[c]), ext_rise_i[c], ext_fall_i[c], ref_cnt, rst_n));
        @(negedge clk);
    endtask

    task automatic t_reset();
        sel_i = {3'd1, 3'd1};
        rst_n = 1'b0;
        repeat (3) cyc("R9 reset quiet");
        sel_i = {3'd2, 3'd2};
        rst_n = 1'b1;
        // After release the divider reads 0..7, so the eighth sample strobes.
        for (int k = 1; k <= 8; k++) begin
            #1;
            check("R9 first strobe after release", cnt_en_o[0], (k == 8));
            @(negedge clk);
        end
    endtask

    task automatic t_stop_direct();
        sel_i = {3'd1, 3'd0};
        repeat (40) cyc("R1 R2 stop and direct");
        sel_i = {3'd0, 3'd1};
        repeat (40) cyc("R1 R2 swapped");
    endtask

    task automatic t_taps();
        sel_i = {3'd3, 3'd2};
        repeat (1100) cyc("R4 R7 ratios 8 and 64");
        sel_i = {3'd5, 3'd4};
        repeat (2100) cyc("R3 R4 ratios 256 and 1024");
    endtask

    task automatic t_clear();
        sel_i = {3'd3, 3'd2};
        repeat (13) cyc("R5 before clear");
        psc_clr_i = 1'b1;
        cyc("R5 clear cycle");
        psc_clr_i = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            #1;
            check("R5 ratio 8 after clear", cnt_en_o[0], (k == 8));
            check("R5 ratio 64 after clear", cnt_en_o[1], 1'b0);
            @(negedge clk);
        end
        repeat (130) cyc("R5 R7 shared phase after clear");
    endtask

    task automatic t_ext();
        sel_i = {3'd7, 3'd6};
        for (int k = 0; k < 24; k++) begin
            ext_rise_i = NCH'(k % 3);
            ext_fall_i = NCH'((k * 5) % 4);
            cyc("R6 external pulses");
        end
        ext_rise_i = '0;
        ext_fall_i = '0;
        sel_i = {3'd6, 3'd7};
        ext_rise_i = 2'b01;
        cyc("R6 rise only");
        ext_rise_i = 2'b00;
        ext_fall_i = 2'b10;
        cyc("R6 fall only");
        ext_fall_i = '0;
    endtask

    task automatic t_latency();
        for (int code = 2; code <= 5; code++) begin
            for (int off = 0; off < 3; off++) begin
                int n = 0;
                int ratio = (code == 2) ? 8 : (code == 3) ? 64 : (code == 4) ? 256 : 1024;
                sel_i[0] = 3'd0;
                repeat (off * 37 + 5) @(negedge clk);
                sel_i[0] = 3'(code);
                n = 0;
                for (int k = 1; k <= ratio + 1; k++) begin
                    #1;
                    if (cnt_en_o[0] && n == 0) n = k;
                    @(negedge clk);
                    if (n != 0) break;
                end
                total = total + 1;
                if (n < 1 || n > ratio) begin
                    bad = bad + 1;
                    $display("FAIL R8 first strobe delay: actual=%0d expected=1..%0d", n, ratio);
                end
            end
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stop_direct();
        t_taps();
        t_clear();
        t_ext();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule